// File: doc/BRIEF.md
# SCSI Initiator Register Front-End

This block is the host-facing register file and command decoder of a SCSI initiator controller. A byte-wide host bus reaches sixteen registers spread on 4-byte strides across a 64-byte window. Writing the command register starts one of a small set of operations: FIFO flush, chip reset, bus reset, transfer, the two status-collection steps, and selection with attention. Each operation leaves its own pattern in the status, interrupt-cause and sequence-step registers and may raise a level interrupt. The interrupt is acknowledged by reading the interrupt-cause register.

Data transfers are handed to an external DMA engine. The engine receives a one-cycle request with a 17-bit length and a direction, and it answers with a done strobe. A 32-byte FIFO carries bytes moved by programmed I/O and the two-byte status response. The target side is reduced to three inputs: which IDs are present, whether the target sends data to the host, and the target's status byte.

Top module: `scsi_fe_regs`

## Requirements
- R1: The register index is `bus_addr[5:2]`. `bus_addr[1:0]` has no effect on which register is accessed.
- R2: Writes to index 0 (low byte) and index 1 (high byte) load a hidden transfer-count image. Indexes 0 and 1 read a separate readback copy. The readback is loaded from the image only by a command-register (index 3) write with bit 7 set.
- R3: Command 0x10 written with bit 7 set produces a one-cycle `dma_req`. With it come `dma_len` equal to the count image, or 65536 when the image is 0, and `dma_to_host` equal to status bit 0 at that moment. Status bit 4 (terminal count, 0x10) is cleared.
- R4: A write to index 0 or index 1 clears status bit 4.
- R5: A `dma_done` pulse sets status bits 7 and 4 and writes 0x10 (bus service) to the interrupt-cause register (index 5). It also zeroes the sequence step (index 6), empties the FIFO and zeroes the readback at indexes 0 and 1. `irq` is raised.
- R6: A read of index 5 clears status bits 7, 6 and 5 and drops `irq`. Status bit 4 and the phase bits are kept.
- R7: Commands 0x42 and 0x43 take the target ID from the last value written to index 4, bits [2:0]. An ID of 7, or an ID whose `tgt_present` bit is 0, gives status 0x80, cause 0x20 (disconnect) and step 0. A valid ID gives cause 0x18 and step 4. Status becomes 0x90 with phase 1 (data-in, if `tgt_data_in`) or phase 0 for 0x42, and phase 2 (command) for 0x43. Both commands empty the FIFO and raise `irq`.
- R8: Command 0x03 writes cause 0x80. It raises `irq` and sets status bit 7 only when bit 6 of the configuration register (index 8) is 0.
- R9: Command 0x01 empties the FIFO and sets cause 0x08 and step 0. It leaves `irq` unchanged.
- R10: Command 0x02 returns every readable register to 0, except index 14, which always reads 0x04. It also drops `irq`.
- R11: Command 0x11 loads the FIFO with `tgt_status` then 0x00, so index 7 reads 2, and raises `irq`. With bit 7 clear it sets status bit 7 only. With bit 7 set it sets status 0x93 (phase 3, status), cause 0x18 and step 4.
- R12: Command 0x12 behaves as 0x11, then sets cause 0x20 and step 0.
- R13: Index 2 pushes on write and pops on read. Index 7 reads the fill count. A push into a full 32-byte FIFO and a pop from an empty one are ignored. An empty FIFO reads 0 at index 2.
- R14: Index 3 reads back the last command byte. Commands 0x00, 0x1A and 0x44 change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Host byte address within the 64-byte window |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe; read side effects occur at the clock edge |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt |
| dma_req | output | 1 | One-cycle request to the DMA engine |
| dma_len | output | 17 | Requested transfer length in bytes |
| dma_to_host | output | 1 | 1 when data moves from target to host |
| dma_done | input | 1 | DMA engine completion strobe |
| tgt_present | input | 7 | One bit per target ID, 1 when that target responds |
| tgt_data_in | input | 1 | Selected target will send data to the host |
| tgt_status | input | 8 | Status byte returned by the target |

## Verification
Assertions check the rules that hold on every cycle. `dma_req` never lasts two cycles. The FIFO count never exceeds its depth, and a pop from empty leaves it empty. A reload copies the count image and a done strobe zeroes the readback. A write to the count registers clears terminal count. Reading the cause register drops the interrupt. `dma_done` always leaves bus service pending, and `irq` is never high without status bit 7. Only the bench's scenarios can show the command-specific encodings. These cover selection results across all eight IDs with a mixed presence map, the gated bus-reset interrupt, the two-byte response ordering and the zero-means-65536 length rule. The bench also shows that commands meant to have no effect really leave the visible registers unchanged.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;

   // command codes (low seven bits of the command byte)
   localparam logic [6:0] CMD_NOP     = 7'h00;
   localparam logic [6:0] CMD_FLUSH   = 7'h01;
   localparam logic [6:0] CMD_CHIPRST = 7'h02;
   localparam logic [6:0] CMD_BUSRST  = 7'h03;
   localparam logic [6:0] CMD_XFER    = 7'h10;
   localparam logic [6:0] CMD_STATSEQ = 7'h11;
   localparam logic [6:0] CMD_MSGOK   = 7'h12;
   localparam logic [6:0] CMD_ATN     = 7'h1A;
   localparam logic [6:0] CMD_SELATN  = 7'h42;
   localparam logic [6:0] CMD_SELSTOP = 7'h43;
   localparam logic [6:0] CMD_ENSEL   = 7'h44;

   // register indexes
   localparam logic [3:0] IX_CNT_LO = 4'h0;
   localparam logic [3:0] IX_CNT_HI = 4'h1;
   localparam logic [3:0] IX_FIFO   = 4'h2;
   localparam logic [3:0] IX_CMD    = 4'h3;
   localparam logic [3:0] IX_STAT   = 4'h4;
   localparam logic [3:0] IX_CAUSE  = 4'h5;
   localparam logic [3:0] IX_STEP   = 4'h6;
   localparam logic [3:0] IX_FLAGS  = 4'h7;
   localparam logic [3:0] IX_CFG    = 4'h8;
   localparam logic [3:0] IX_REV    = 4'hE;

   // interrupt-cause codes
   localparam logic [7:0] CAUSE_RESET = 8'h80;
   localparam logic [7:0] CAUSE_DISC  = 8'h20;
   localparam logic [7:0] CAUSE_SVC   = 8'h10;
   localparam logic [7:0] CAUSE_FDONE = 8'h08;

   localparam logic [7:0] STEP_IDLE    = 8'h00;
   localparam logic [7:0] STEP_CMDDONE = 8'h04;

   typedef enum logic [2:0] {
      PH_DOUT  = 3'd0,
      PH_DIN   = 3'd1,
      PH_CMD   = 3'd2,
      PH_STAT  = 3'd3,
      PH_MSGIN = 3'd7
   } phase_e;

endpackage

// File: rtl/scsi_fe_xfer_cnt.sv
module scsi_fe_xfer_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [7:0]    wdata,
   input  logic          reload,
   input  logic          zero,
   output logic [CW-1:0] rb,
   output logic [CW:0]   xfer_len
);
   localparam int HIW = CW - 8;

   generate
      if (CW < 9 || CW > 16) begin : g_bad_cw
         $error("scsi_fe_xfer_cnt: CW must lie in 9..16");
      end
   endgenerate

   logic [CW-1:0] img_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         img_q <= '0;
         rb    <= '0;
      end else if (clr) begin
         img_q <= '0;
         rb    <= '0;
      end else begin
         if (wr_lo) img_q[7:0]    <= wdata;
         if (wr_hi) img_q[CW-1:8] <= wdata[HIW-1:0];
         if (zero)        rb <= '0;
         else if (reload) rb <= img_q;
      end
   end

   assign xfer_len = (img_q == '0) ? (CW+1)'(1) << CW : {1'b0, img_q};

   p_reload_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !zero && !clr) |=> (rb == $past(img_q)));

   p_done_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !clr) |=> (rb == '0));

endmodule

// File: rtl/scsi_fe_fifo.sv
module scsi_fe_fifo #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CNTW = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push,
   input  logic [DW-1:0]   push_data,
   input  logic            pop,
   input  logic            ld_pair,
   input  logic [DW-1:0]   ld_b0,
   input  logic [DW-1:0]   ld_b1,
   output logic [DW-1:0]   head,
   output logic [CNTW-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 128) begin : g_bad_depth
         $error("scsi_fe_fifo: DEPTH must be a power of two in 2..128");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic          do_push, do_pop;
   logic [CNTW-1:0] cnt_nx;

   assign do_push = push && (count != CNTW'(DEPTH));
   assign do_pop  = pop && (count != '0);

   always_comb begin
      cnt_nx = count;
      if (do_push) cnt_nx = cnt_nx + 1'b1;
      if (do_pop)  cnt_nx = cnt_nx - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (ld_pair) begin
         mem[0] <= ld_b0;
         mem[1] <= ld_b1;
      end else if (do_push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (ld_pair) begin
         rd_ptr <= '0;
         wr_ptr <= AW'(2);
         count  <= CNTW'(2);
      end else begin
         count <= cnt_nx;
         if (cnt_nx == '0) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end

   assign head = (count == '0) ? '0 : mem[rd_ptr];

   p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));

   p_empty_pop_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !ld_pair && count == '0) |=> (count == '0));

endmodule

// File: rtl/scsi_fe_regs.sv
module scsi_fe_regs
   import scsi_fe_pkg::*;
#(
   parameter int         FIFO_DEPTH = 32,
   parameter int         CNT_W      = 16,
   parameter int         NUM_IDS    = 7,
   parameter logic [7:0] REV_ID     = 8'h04
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [5:0]         bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic               irq,
   output logic               dma_req,
   output logic [CNT_W:0]     dma_len,
   output logic               dma_to_host,
   input  logic               dma_done,
   input  logic [NUM_IDS-1:0] tgt_present,
   input  logic               tgt_data_in,
   input  logic [7:0]         tgt_status
);
   localparam int FCW = $clog2(FIFO_DEPTH) + 1;

   generate
      if (NUM_IDS < 1 || NUM_IDS > 7) begin : g_bad_ids
         $error("scsi_fe_regs: NUM_IDS must lie in 1..7");
      end
   endgenerate

   // ---------------- decode ----------------
   logic [3:0] idx;
   logic       rd_ev, wr_cmd, dma_flag, chip_rst;
   logic [6:0] cmd;
   assign idx      = bus_addr[5:2];
   assign rd_ev    = bus_rd && !bus_wr;
   assign wr_cmd   = bus_wr && (idx == IX_CMD);
   assign cmd      = bus_wdata[6:0];
   assign dma_flag = bus_wdata[7];
   assign chip_rst = wr_cmd && (cmd == CMD_CHIPRST);

   logic unused_addr_lanes;
   assign unused_addr_lanes = ^bus_addr[1:0];

   // ---------------- target validity map ----------------
   logic [7:0] id_ok;
   generate
      for (genvar g = 0; g < 8; g++) begin : g_id
         if (g < NUM_IDS) begin : g_real
            assign id_ok[g] = tgt_present[g];
         end else begin : g_none
            assign id_ok[g] = 1'b0;
         end
      end
   endgenerate

   // ---------------- transfer counter ----------------
   logic [CNT_W-1:0] cnt_rb;
   logic [CNT_W:0]   cnt_len;

   scsi_fe_xfer_cnt #(.CW(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (chip_rst),
      .wr_lo    (bus_wr && idx == IX_CNT_LO),
      .wr_hi    (bus_wr && idx == IX_CNT_HI),
      .wdata    (bus_wdata),
      .reload   (wr_cmd && dma_flag),
      .zero     (dma_done),
      .rb       (cnt_rb),
      .xfer_len (cnt_len)
   );

   // ---------------- byte FIFO ----------------
   logic [7:0]     fifo_head;
   logic [FCW-1:0] fifo_cnt;
   logic           fifo_clr, resp_ld;

   assign fifo_clr = chip_rst || dma_done ||
                     (wr_cmd && (cmd == CMD_FLUSH || cmd == CMD_SELATN || cmd == CMD_SELSTOP));
   assign resp_ld  = wr_cmd && (cmd == CMD_STATSEQ || cmd == CMD_MSGOK);

   scsi_fe_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (fifo_clr),
      .push      (bus_wr && idx == IX_FIFO),
      .push_data (bus_wdata),
      .pop       (rd_ev && idx == IX_FIFO),
      .ld_pair   (resp_ld),
      .ld_b0     (tgt_status),
      .ld_b1     (8'h00),
      .head      (fifo_head),
      .count     (fifo_cnt)
   );

   // ---------------- control state ----------------
   logic [7:0] stat_q, cause_q, step_q, cmd_q, cfg_q;
   logic [2:0] busid_q;
   logic       irq_q, req_q, dir_q;
   logic [CNT_W:0] len_q;
   logic       tgt_ok;
   phase_e     sel_ph;

   assign tgt_ok = id_ok[busid_q];
   assign sel_ph = (cmd == CMD_SELSTOP) ? PH_CMD : (tgt_data_in ? PH_DIN : PH_DOUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         cause_q <= '0;
         step_q  <= '0;
         cmd_q   <= '0;
         cfg_q   <= '0;
         busid_q <= '0;
         irq_q   <= 1'b0;
         req_q   <= 1'b0;
         dir_q   <= 1'b0;
         len_q   <= '0;
      end else begin
         req_q <= 1'b0;
         if (rd_ev && idx == IX_CAUSE) begin
            stat_q[7:5] <= 3'b000;
            irq_q       <= 1'b0;
         end
         if (bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_HI)) stat_q[4] <= 1'b0;
         if (bus_wr && idx == IX_STAT) busid_q <= bus_wdata[2:0];
         if (bus_wr && idx == IX_CFG)  cfg_q   <= bus_wdata;
         if (wr_cmd) begin
            cmd_q <= bus_wdata;
            unique case (cmd)
               CMD_FLUSH: begin
                  cause_q <= CAUSE_FDONE;
                  step_q  <= STEP_IDLE;
               end
               CMD_CHIPRST: begin
                  stat_q  <= '0;
                  cause_q <= '0;
                  step_q  <= '0;
                  cmd_q   <= '0;
                  cfg_q   <= '0;
                  busid_q <= '0;
                  irq_q   <= 1'b0;
               end
               CMD_BUSRST: begin
                  cause_q <= CAUSE_RESET;
                  if (!cfg_q[6]) begin
                     irq_q     <= 1'b1;
                     stat_q[7] <= 1'b1;
                  end
               end
               CMD_XFER: begin
                  if (dma_flag) begin
                     req_q     <= 1'b1;
                     len_q     <= cnt_len;
                     dir_q     <= stat_q[0];
                     stat_q[4] <= 1'b0;
                  end
               end
               CMD_STATSEQ, CMD_MSGOK: begin
                  irq_q <= 1'b1;
                  if (dma_flag) begin
                     stat_q  <= {5'b10010, PH_STAT};
                     cause_q <= CAUSE_SVC | CAUSE_FDONE;
                     step_q  <= STEP_CMDDONE;
                  end else begin
                     stat_q[7] <= 1'b1;
                  end
                  if (cmd == CMD_MSGOK) begin
                     cause_q <= CAUSE_DISC;
                     step_q  <= STEP_IDLE;
                  end
               end
               CMD_SELATN, CMD_SELSTOP: begin
                  irq_q <= 1'b1;
                  if (!tgt_ok) begin
                     stat_q  <= 8'h80;
                     cause_q <= CAUSE_DISC;
                     step_q  <= STEP_IDLE;
                  end else begin
                     stat_q  <= {5'b10010, sel_ph};
                     cause_q <= CAUSE_SVC | CAUSE_FDONE;
                     step_q  <= STEP_CMDDONE;
                  end
               end
               default: ;
            endcase
         end
         if (dma_done && !chip_rst) begin
            stat_q[7] <= 1'b1;
            stat_q[4] <= 1'b1;
            cause_q   <= CAUSE_SVC;
            step_q    <= STEP_IDLE;
            irq_q     <= 1'b1;
         end
      end
   end

   assign irq         = irq_q;
   assign dma_req     = req_q;
   assign dma_len     = len_q;
   assign dma_to_host = dir_q;

   // ---------------- read mux ----------------
   always_comb begin
      unique case (idx)
         IX_CNT_LO: bus_rdata = cnt_rb[7:0];
         IX_CNT_HI: bus_rdata = 8'(cnt_rb >> 8);
         IX_FIFO:   bus_rdata = fifo_head;
         IX_CMD:    bus_rdata = cmd_q;
         IX_STAT:   bus_rdata = stat_q;
         IX_CAUSE:  bus_rdata = cause_q;
         IX_STEP:   bus_rdata = step_q;
         IX_FLAGS:  bus_rdata = 8'(fifo_cnt);
         IX_CFG:    bus_rdata = cfg_q;
         IX_REV:    bus_rdata = REV_ID;
         default:   bus_rdata = 8'h00;
      endcase
   end

   // ---------------- assertions ----------------
   p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> !dma_req);

   p_cnt_write_clears_tc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_HI) && !dma_done) |=> !stat_q[4]);

   p_done_reports_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_done && !chip_rst) |=> (irq && cause_q == CAUSE_SVC && step_q == STEP_IDLE && stat_q[4]));

   p_cause_read_acks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ev && idx == IX_CAUSE && !dma_done) |=> (!irq && stat_q[7:5] == 3'b000));

   p_irq_implies_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> stat_q[7]);

endmodule

// File: tb/scsi_fe_regs_bench.sv
module scsi_fe_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        irq, dma_req, dma_to_host;
   logic [16:0] dma_len;
   logic        dma_done = 1'b0;
   logic [6:0]  tgt_present = 7'b1010101;
   logic        tgt_data_in = 1'b0;
   logic [7:0]  tgt_status = 8'h00;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   scsi_fe_regs u_scsi_fe_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req),
      .dma_len(dma_len), .dma_to_host(dma_to_host), .dma_done(dma_done),
      .tgt_present(tgt_present), .tgt_data_in(tgt_data_in), .tgt_status(tgt_status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      dma_done = 1'b1;
      @(posedge clk); #1;
      dma_done = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [7:0] b;
      logic [15:0] cvals [5];
      cvals[0] = 16'h0000; cvals[1] = 16'h0001; cvals[2] = 16'h00FF;
      cvals[3] = 16'h8000; cvals[4] = 16'hFFFF;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state (R10)
      rd(6'h10, v); chk("R10 reset status", v, 8'h00);
      rd(6'h14, v); chk("R10 reset cause", v, 8'h00);
      rd(6'h38, v); chk("R10 revision id", v, 8'h04);
      chk("R10 reset irq", irq, 1'b0);

      // R2 / R1: image vs readback, address low bits ignored
      wr(6'h01, 8'h34);
      wr(6'h06, 8'h12);
      rd(6'h03, v); chk("R2 readback not yet loaded lo", v, 8'h00);
      wr(6'h0E, 8'h80);
      rd(6'h02, v); chk("R1 R2 reload lo", v, 8'h34);
      rd(6'h07, v); chk("R1 R2 reload hi", v, 8'h12);
      rd(6'h0F, v); chk("R14 command readback", v, 8'h80);

      // R13: FIFO fill past depth, then drain past empty
      wr(6'h0C, 8'h01);
      for (int i = 0; i < 34; i++) wr(6'h08, 8'((i * 7 + 3) & 8'hFF));
      rd(6'h1C, v); chk("R13 flags at full", v, 8'd32);
      for (int i = 0; i < 32; i++) begin
         rd(6'h08, v); chk("R13 pop order", v, 8'((i * 7 + 3) & 8'hFF));
      end
      rd(6'h08, v); chk("R13 underflow reads zero", v, 8'h00);
      rd(6'h1C, v); chk("R13 flags after underflow", v, 8'd0);

      // R9: flush
      for (int i = 0; i < 3; i++) wr(6'h08, 8'hA0);
      wr(6'h0C, 8'h01);
      rd(6'h1C, v); chk("R9 flush empties", v, 8'd0);
      rd(6'h14, v); chk("R9 flush cause", v, 8'h08);
      rd(6'h18, v); chk("R9 flush step", v, 8'h00);
      chk("R9 flush no irq", irq, 1'b0);

      // R7: selection over every ID, both select commands
      for (int id = 0; id < 8; id++) begin
         for (int k = 0; k < 2; k++) begin
            logic ok;
            logic [7:0] exp_st;
            ok = (id < 7) && tgt_present[id % 7];
            tgt_data_in = id[0];
            wr(6'h08, 8'h55);
            wr(6'h10, 8'(id));
            wr(6'h0C, k ? 8'h43 : 8'h42);
            exp_st = !ok ? 8'h80 : (k ? 8'h92 : (id[0] ? 8'h91 : 8'h90));
            chk("R7 select irq", irq, 1'b1);
            rd(6'h10, v); chk("R7 select status", v, exp_st);
            rd(6'h18, v); chk("R7 select step", v, ok ? 8'h04 : 8'h00);
            rd(6'h1C, v); chk("R7 select empties fifo", v, 8'd0);
            rd(6'h14, v); chk("R7 select cause", v, ok ? 8'h18 : 8'h20);
            chk("R6 irq dropped", irq, 1'b0);
         end
      end

      // valid data-in selection, then acknowledge
      tgt_data_in = 1'b1;
      wr(6'h10, 8'h02);
      wr(6'h0C, 8'h42);
      rd(6'h14, v);
      rd(6'h10, v); chk("R6 ack keeps tc and phase", v, 8'h11);

      // R3/R4/R5 sweep over counter values
      foreach (cvals[j]) begin
         wr(6'h00, cvals[j][7:0]);
         rd(6'h10, v); chk("R4 count write clears tc", v, 8'h01);
         wr(6'h04, cvals[j][15:8]);
         wr(6'h0C, 8'h90);
         chk("R3 req pulse", dma_req, 1'b1);
         chk("R3 length", dma_len, (cvals[j] == 16'h0) ? 17'h10000 : {1'b0, cvals[j]});
         chk("R3 direction", dma_to_host, 1'b1);
         @(posedge clk); #1;
         chk("R3 req single cycle", dma_req, 1'b0);
         rd(6'h00, v); chk("R2 reload on dma cmd lo", v, cvals[j][7:0]);
         rd(6'h04, v); chk("R2 reload on dma cmd hi", v, cvals[j][15:8]);
         wr(6'h08, 8'h77);
         done_pulse();
         chk("R5 done irq", irq, 1'b1);
         rd(6'h10, v); chk("R5 done status", v, 8'h91);
         rd(6'h18, v); chk("R5 done step", v, 8'h00);
         rd(6'h1C, v); chk("R5 done flags", v, 8'h00);
         rd(6'h00, v); chk("R5 done readback lo", v, 8'h00);
         rd(6'h04, v); chk("R5 done readback hi", v, 8'h00);
         rd(6'h14, v); chk("R5 done cause", v, 8'h10);
         rd(6'h10, v); chk("R6 ack keeps tc", v, 8'h11);
      end

      // R8: bus reset gated by configuration bit 6
      wr(6'h20, 8'h40);
      wr(6'h0C, 8'h03);
      chk("R8 masked irq", irq, 1'b0);
      rd(6'h10, v); chk("R8 masked status", v, 8'h11);
      rd(6'h14, v); chk("R8 reset cause", v, 8'h80);
      wr(6'h20, 8'h00);
      wr(6'h0C, 8'h03);
      chk("R8 unmasked irq", irq, 1'b1);
      rd(6'h10, v); chk("R8 unmasked status", v, 8'h91);
      rd(6'h14, v);

      // R14: no-effect commands
      foreach (cvals[j]) begin
         if (j < 3) begin
            logic [7:0] c;
            c = (j == 0) ? 8'h00 : ((j == 1) ? 8'h1A : 8'h44);
            wr(6'h0C, c);
            rd(6'h10, v); chk("R14 status unchanged", v, 8'h11);
            rd(6'h18, v); chk("R14 step unchanged", v, 8'h00);
            rd(6'h0C, v); chk("R14 command readback", v, c);
            chk("R14 irq unchanged", irq, 1'b0);
         end
      end

      // R11: status sequence, PIO then DMA
      tgt_status = 8'h02;
      wr(6'h0C, 8'h11);
      chk("R11 irq", irq, 1'b1);
      rd(6'h1C, v); chk("R11 flags two", v, 8'd2);
      rd(6'h10, v); chk("R11 pio status", v, 8'h91);
      rd(6'h08, b); chk("R11 first byte", b, 8'h02);
      rd(6'h08, b); chk("R11 second byte", b, 8'h00);
      rd(6'h14, v);
      wr(6'h0C, 8'h91);
      rd(6'h10, v); chk("R11 dma status", v, 8'h93);
      rd(6'h18, v); chk("R11 dma step", v, 8'h04);
      rd(6'h14, v); chk("R11 dma cause", v, 8'h18);

      // R12: message accepted
      tgt_status = 8'h5A;
      wr(6'h0C, 8'h12);
      rd(6'h1C, v); chk("R12 flags two", v, 8'd2);
      rd(6'h08, b); chk("R12 first byte", b, 8'h5A);
      rd(6'h18, v); chk("R12 step", v, 8'h00);
      chk("R12 irq", irq, 1'b1);
      rd(6'h14, v); chk("R12 cause", v, 8'h20);

      // R10: chip reset clears everything
      wr(6'h20, 8'hC3);
      wr(6'h00, 8'h9);
      wr(6'h0C, 8'h80);
      wr(6'h0C, 8'h03);
      wr(6'h0C, 8'h02);
      chk("R10 irq low", irq, 1'b0);
      for (int r = 0; r < 16; r++) begin
         if (r != 2) begin
            rd(6'(r * 4), v);
            chk("R10 register cleared", v, (r == 14) ? 8'h04 : 8'h00);
         end
      end
      wr(6'h0C, 8'h80);
      rd(6'h00, v); chk("R10 count image cleared", v, 8'h00);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule